// File: doc/BRIEF.md
# Buck Phase Gate Drive Sequencer

This block drives the high-side and low-side gate enables of one synchronous buck phase. External comparators have already sorted the PWM input into region flags: high, low or mid. The sequencer runs on one clock. It brings every asynchronous flag into the clock domain and turns a stable region into a command. It then steps a gate state machine so that one switch is off and proven discharged before the other switch turns on.

A controller with a three-level output can park the phase by releasing its PWM pin into the mid band. Once that band has been held for a hold-off time, both gates turn off. An active-low mode input enables diode emulation. In that mode a zero-crossing flag ends the low-side pulse, but only after a blanking interval. A supply-good flag clamps both gates off for as long as it is low. All delays are counted in clock cycles and set by parameters.

Top module: `gate_seq_top`

## Requirements
- R1: A high-region command turns GL off and then turns GH on. A low-region command turns GH off and then turns GL on.
- R2: The mid region must be sampled for HOLD_CYC consecutive cycles before both gates are forced off. A shorter visit to the mid region leaves the gates as they were.
- R3: A gate turns on only after the opposite gate's discharged flag has been seen for DT_CYC consecutive cycles. While that flag stays low, the gate stays off. GH and GL are never high together.
- R4: With diode emulation on (mode input at 0), GL turns on after the normal dead time during a low command. It turns off on a zero-crossing flag at 1, but only after GL has been on for BLANK_CYC cycles. With no zero crossing, GL stays on.
- R5: With diode emulation off (mode input at 1), GL stays on for the whole low command whatever the zero-crossing flag does.
- R6: A mid-region hold-off that expires turns GL off in both modes, whatever the inductor current.
- R7: While the supply-good flag is 0, GH and GL are both held at 0, including when the PWM input is in the high region.
- R8: A high region counts only after MIN_ON_CYC consecutive samples. A shorter high pulse during a low command leaves GL on and GH off.
- R9: Leaving the mid-region off state into the high or low region restarts sequencing through the dead-time path.
- R10: A sample whose region flags are not exactly one of high or low counts as mid. This covers more than one flag set at once and no flag set.
- R11: After reset, and after the supply-good flag returns to 1, both gates stay off until the first valid high or low region.
- R12: Once diode emulation has turned GL off, GL stays off until the next high-to-low command. Toggling the zero-crossing flag in the meantime does not turn it back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi_i | input | 1 | Comparator flag: PWM in high region |
| pwm_lo_i | input | 1 | Comparator flag: PWM in low region |
| pwm_mid_i | input | 1 | Comparator flag: PWM in mid (released) band |
| de_en_n_i | input | 1 | Diode emulation enable, active low |
| zc_i | input | 1 | Zero-crossing flag, 1 when inductor current is at or below zero |
| gh_dis_i | input | 1 | High-side gate discharged flag |
| gl_dis_i | input | 1 | Low-side gate discharged flag |
| vgood_i | input | 1 | Supply good flag; 0 locks out both gates |
| gh_o | output | 1 | High-side gate enable |
| gl_o | output | 1 | Low-side gate enable |

## Verification
The hardest state to reach is diode emulation holding GL off after a zero crossing. Getting there needs a full high-to-low cycle with the mode input at 0 and the zero-crossing flag already at 1 during blanking. The stimulus then has to toggle the flag, and show that GL stays low until a new high region arrives. The dead-time interlock is just as hard to reach, because the bench normally derives the discharged flags from the gate outputs. The stimulus can hold one flag low to show that the opposite gate waits indefinitely. The hold-off limit is checked from both sides: a short mid visit that must change nothing, and a long one that must turn both gates off.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
  typedef enum logic [1:0] {RG_MID, RG_HI, RG_LO} region_t;
  typedef enum logic [1:0] {CMD_OFF, CMD_HIGH, CMD_LOW} cmd_t;
  typedef enum logic [2:0] {
    ST_OFF, ST_GH_WAIT, ST_GH_ON, ST_GL_WAIT, ST_GL_ON, ST_DE_OFF
  } gate_st_t;
endpackage

// File: rtl/gsq_sync.sv
module gsq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gsq_pwm_classify.sv
module gsq_pwm_classify
  import gsq_pkg::*;
#(
  parameter int HOLD_CYC   = 30,
  parameter int MIN_ON_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic hi,
  input  logic lo,
  input  logic mid,
  output cmd_t cmd
);
  localparam int MW = $clog2(HOLD_CYC + 1);
  localparam int HW = $clog2(MIN_ON_CYC + 1);
  localparam logic [MW-1:0] MID_LAST = MW'(HOLD_CYC - 1);
  localparam logic [MW-1:0] MID_SAT  = MW'(HOLD_CYC);
  localparam logic [HW-1:0] HI_LAST  = HW'(MIN_ON_CYC - 1);
  localparam logic [HW-1:0] HI_SAT   = HW'(MIN_ON_CYC);

  region_t        region;
  logic [MW-1:0]  mid_cnt;
  logic [HW-1:0]  hi_cnt;
  cmd_t           cmd_q;

  // anything other than exactly one of high/low is the mid band
  always_comb begin
    unique case ({hi, lo, mid})
      3'b100:  region = RG_HI;
      3'b010:  region = RG_LO;
      default: region = RG_MID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_OFF;
      mid_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      unique case (region)
        RG_HI: begin
          mid_cnt <= '0;
          if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
          if (hi_cnt >= HI_LAST) cmd_q <= CMD_HIGH;
        end
        RG_LO: begin
          mid_cnt <= '0;
          hi_cnt  <= '0;
          cmd_q   <= CMD_LOW;
        end
        default: begin
          hi_cnt <= '0;
          if (mid_cnt != MID_SAT) mid_cnt <= mid_cnt + 1'b1;
          if (mid_cnt >= MID_LAST) cmd_q <= CMD_OFF;
        end
      endcase
    end
  end

  assign cmd = cmd_q;

  // R8
  cmd_high_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_HIGH && $past(cmd_q) != CMD_HIGH) |-> $past(region == RG_HI));

  // R2
  cmd_off_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_OFF && $past(cmd_q) != CMD_OFF) |-> $past(region == RG_MID));
endmodule

// File: rtl/gsq_gate_fsm.sv
module gsq_gate_fsm
  import gsq_pkg::*;
#(
  parameter int DT_CYC    = 2,
  parameter int BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  cmd_t cmd,
  input  logic ok,
  input  logic de_on,
  input  logic zc,
  input  logic gh_dis,
  input  logic gl_dis,
  output logic gh,
  output logic gl
);
  localparam int DW = $clog2(DT_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [DW-1:0] DT_LAST   = DW'(DT_CYC - 1);
  localparam logic [DW-1:0] DT_SAT    = DW'(DT_CYC);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  gate_st_t       state_q, nstate;
  logic [DW-1:0]  dt_cnt;
  logic [BW-1:0]  blk_cnt;
  logic           gh_q, gl_q;

  always_comb begin
    nstate = state_q;
    if (!ok) begin
      nstate = ST_OFF;
    end else begin
      unique case (cmd)
        CMD_HIGH: begin
          unique case (state_q)
            ST_GH_ON:   nstate = ST_GH_ON;
            ST_GH_WAIT: if (gl_dis && dt_cnt == DT_LAST) nstate = ST_GH_ON;
            default:    nstate = ST_GH_WAIT;
          endcase
        end
        CMD_LOW: begin
          unique case (state_q)
            ST_GL_ON:   if (de_on && zc && blk_cnt == BLANK_END) nstate = ST_DE_OFF;
            ST_DE_OFF:  nstate = ST_DE_OFF;
            ST_GL_WAIT: if (gh_dis && dt_cnt == DT_LAST) nstate = ST_GL_ON;
            default:    nstate = ST_GL_WAIT;
          endcase
        end
        default: nstate = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      dt_cnt  <= '0;
      blk_cnt <= '0;
      gh_q    <= 1'b0;
      gl_q    <= 1'b0;
    end else begin
      state_q <= nstate;
      gh_q    <= (nstate == ST_GH_ON);
      gl_q    <= (nstate == ST_GL_ON);
      if (nstate != state_q) begin
        dt_cnt <= '0;
      end else if ((state_q == ST_GH_WAIT && gl_dis) ||
                   (state_q == ST_GL_WAIT && gh_dis)) begin
        if (dt_cnt != DT_SAT) dt_cnt <= dt_cnt + 1'b1;
      end else begin
        dt_cnt <= '0;
      end
      if (state_q == ST_GL_ON && nstate == ST_GL_ON) begin
        if (blk_cnt != BLANK_END) blk_cnt <= blk_cnt + 1'b1;
      end else begin
        blk_cnt <= '0;
      end
    end
  end

  assign gh = gh_q;
  assign gl = gl_q;

  // R7
  lockout_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    !ok |=> (!gh_q && !gl_q));

  // R3
  gh_needs_dis_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gh_q) |-> $past(gl_dis && !gl_q));

  // R3
  gl_needs_dis_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gl_q) |-> $past(gh_dis && !gh_q));

  // R12
  de_stay_off_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DE_OFF && cmd == CMD_LOW && ok) |=> !gl_q);

  // R5
  no_de_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GL_ON && !de_on && cmd == CMD_LOW && ok) |=> gl_q);
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 30,
  parameter int MIN_ON_CYC  = 6,
  parameter int DT_CYC      = 2,
  parameter int BLANK_CYC   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  input  logic pwm_mid_i,
  input  logic de_en_n_i,
  input  logic zc_i,
  input  logic gh_dis_i,
  input  logic gl_dis_i,
  input  logic vgood_i,
  output logic gh_o,
  output logic gl_o
);
  localparam int NIN = 8;
  localparam logic [NIN-1:0] SYNC_RST = 8'b0000_1000;

  logic [NIN-1:0] raw, syn;
  cmd_t cmd;

  assign raw = {vgood_i, gl_dis_i, gh_dis_i, zc_i,
                de_en_n_i, pwm_mid_i, pwm_lo_i, pwm_hi_i};

  gsq_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  gsq_pwm_classify #(.HOLD_CYC(HOLD_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_cls (
    .clk(clk), .rst(rst),
    .hi(syn[0]), .lo(syn[1]), .mid(syn[2]),
    .cmd(cmd)
  );

  gsq_gate_fsm #(.DT_CYC(DT_CYC), .BLANK_CYC(BLANK_CYC)) u_fsm (
    .clk(clk), .rst(rst), .cmd(cmd),
    .ok(syn[7]), .de_on(!syn[3]), .zc(syn[4]),
    .gh_dis(syn[5]), .gl_dis(syn[6]),
    .gh(gh_o), .gl(gl_o)
  );

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(gh_o && gl_o));
endmodule

// File: tb/tb_gate_seq_top.sv
`timescale 1ns/1ps
module tb_gate_seq_top;
  localparam int HOLD = 30;
  localparam int MINON = 6;
  localparam int DT = 2;
  localparam int BLANK = 8;

  typedef struct {
    bit    hold;
    bit    gh;
    bit    gl;
    int    n;
    string req;
  } exp_t;

  logic clk = 0, rst = 1;
  logic hi = 0, lo = 0, mid = 0, de_n = 1, zc = 0, vgood = 0;
  logic blk_gh = 0, blk_gl = 0;
  logic gh, gl;
  logic gh_dis, gl_dis;
  int checks = 0, failures = 0, overlaps = 0;
  bit finished = 0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  assign gh_dis = !gh && !blk_gh;
  assign gl_dis = !gl && !blk_gl;

  gate_seq_top #(.SYNC_STAGES(2), .HOLD_CYC(HOLD), .MIN_ON_CYC(MINON),
                 .DT_CYC(DT), .BLANK_CYC(BLANK)) dut (
    .clk(clk), .rst(rst), .pwm_hi_i(hi), .pwm_lo_i(lo), .pwm_mid_i(mid),
    .de_en_n_i(de_n), .zc_i(zc), .gh_dis_i(gh_dis), .gl_dis_i(gl_dis),
    .vgood_i(vgood), .gh_o(gh), .gl_o(gl)
  );

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        exp_t e;
        bit ok;
        logic agh, agl;
        e = exp_q[0];
        agh = gh; agl = gl;
        if (e.hold) begin
          ok = 1;
          for (int k = 0; k < e.n; k++) begin
            if (ok && (gh !== e.gh || gl !== e.gl)) begin
              ok = 0; agh = gh; agl = gl;
            end
            if (k != e.n - 1) @(negedge clk);
          end
        end else begin
          ok = 0;
          for (int k = 0; k < e.n; k++) begin
            agh = gh; agl = gl;
            if (gh === e.gh && gl === e.gl) begin
              ok = 1;
              break;
            end
            @(negedge clk);
          end
        end
        checks++;
        if (!ok) begin
          failures++;
          $display("FAIL %s: %s gh/gl actual=%b%b expected=%b%b", e.req,
                   e.hold ? "hold" : "reach", agh, agl, e.gh, e.gl);
        end
        void'(exp_q.pop_front());
      end
    end
  end

  always @(negedge clk) if (!rst && gh === 1'b1 && gl === 1'b1) overlaps++;

  task automatic expect_st(input bit hold_m, input bit egh, input bit egl,
                           input int n, input string req);
    exp_t e;
    e.hold = hold_m; e.gh = egh; e.gl = egl; e.n = n; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic pwm(input bit h, input bit l, input bit m);
    @(negedge clk);
    hi = h; lo = l; mid = m;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run hung actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(5);
    rst = 0;
    // R11 reset state, lockout active
    expect_st(1, 0, 0, 5, "R11");
    vgood = 1;
    // R11 released, PWM released: stay off
    expect_st(1, 0, 0, 20, "R11");

    // R1 low then high sequencing
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R1");
    pwm(1, 0, 0);
    expect_st(0, 0, 0, 30, "R1");
    expect_st(0, 1, 0, 30, "R1");

    // R8 short high pulse during a low command
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R8");
    pwm(1, 0, 0); idle(3); pwm(0, 1, 0);
    expect_st(1, 0, 1, 30, "R8");

    // R2 short mid visit while high
    pwm(1, 0, 0);
    expect_st(0, 1, 0, 40, "R2");
    pwm(0, 0, 1); idle(10); pwm(1, 0, 0);
    expect_st(1, 1, 0, 50, "R2");
    // R2 long mid visit
    pwm(0, 0, 1);
    expect_st(1, 1, 0, HOLD - 2, "R2");
    expect_st(0, 0, 0, 20, "R2");

    // R9 leave tri-state into low
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R9");

    // R3 high-side gate not discharged blocks GL
    pwm(1, 0, 0);
    expect_st(0, 1, 0, 40, "R3");
    blk_gh = 1;
    pwm(0, 1, 0);
    expect_st(0, 0, 0, 20, "R3");
    expect_st(1, 0, 0, 20, "R3");
    blk_gh = 0;
    expect_st(0, 0, 1, 15, "R3");
    // R3 low-side gate not discharged blocks GH
    blk_gl = 1;
    pwm(1, 0, 0);
    expect_st(0, 0, 0, 30, "R3");
    expect_st(1, 0, 0, 20, "R3");
    blk_gl = 0;
    expect_st(0, 1, 0, 15, "R3");

    // R4 diode emulation: zero crossing already present, honoured after blanking
    de_n = 0; zc = 1;
    idle(4);
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R4");
    expect_st(1, 0, 1, BLANK - 2, "R4");
    expect_st(0, 0, 0, 8, "R4");
    // R12 no re-arm when the flag toggles
    zc = 0;
    expect_st(1, 0, 0, 20, "R12");
    zc = 1;
    expect_st(1, 0, 0, 20, "R12");
    // R4 no zero crossing: GL stays on
    zc = 0;
    pwm(1, 0, 0);
    expect_st(0, 1, 0, 40, "R4");
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R4");
    expect_st(1, 0, 1, 20, "R4");
    // R6 tri-state turns GL off in emulation mode
    pwm(0, 0, 1);
    expect_st(0, 0, 0, HOLD + 20, "R6");

    // R5 emulation disabled: zero crossing ignored
    de_n = 1;
    pwm(1, 0, 0);
    expect_st(0, 1, 0, 40, "R5");
    zc = 1;
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R5");
    expect_st(1, 0, 1, 40, "R5");
    // R6 tri-state turns GL off with emulation disabled
    pwm(0, 0, 1);
    expect_st(0, 0, 0, HOLD + 20, "R6");
    zc = 0;

    // R10 conflicting flags act as mid
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R10");
    pwm(1, 1, 0);
    expect_st(1, 0, 1, 20, "R10");
    expect_st(0, 0, 0, HOLD + 20, "R10");

    // R7 lockout while high
    pwm(1, 0, 0);
    expect_st(0, 1, 0, 40, "R7");
    vgood = 0;
    expect_st(0, 0, 0, 8, "R7");
    expect_st(1, 0, 0, 20, "R7");
    // R11 release with PWM released: wait for valid region
    pwm(0, 0, 1);
    idle(HOLD + 10);
    vgood = 1;
    expect_st(1, 0, 0, 20, "R11");
    pwm(0, 1, 0);
    expect_st(0, 0, 1, 30, "R11");

    // R3 overlap never seen over the whole run
    checks++;
    if (overlaps != 0) begin
      failures++;
      $display("FAIL R3: overlap cycles actual=%0d expected=0", overlaps);
    end
    idle(5);
    finish_run();
  end
endmodule